// File: doc/BRIEF.md
# Multi-Channel DMA Priority Arbiter

This block chooses which of several DMA channels owns the shared bus for the next block transaction. Every channel drives a request line and a 2-bit priority level set by software. The arbiter grants exactly one channel, holds that grant for the whole block, and chooses again only when the block-done pulse arrives. There is never more than one block on the bus.

The highest level wins. Among channels at the same level, the lower channel number wins. The channel that has just finished a block is left out of the following round. This lets other requesting channels take turns with a high-priority channel instead of waiting behind it. The excluded channel is back in contention one round later. If it is the only channel still requesting, it is granted again so the bus does not go idle. The data path, address generation and bus protocol are handled outside this block.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While rst_n is low at a rising clock edge, the grant, the valid flag and the exclusion record are all cleared on that edge.
- R2: The grant vector has at most one bit set, and grant_vld is high exactly when a grant bit is set. Bit i of the grant means channel i.
- R3: Priority levels use 2'b11 for very high, 2'b10 for high, 2'b01 for medium and 2'b00 for low. The level of channel i sits at bits [2i+1:2i] of the level bus. A requesting channel at a higher level always wins over one at a lower level.
- R4: Among requesting channels at the same level, the one with the lowest channel number wins.
- R5: When the arbiter is idle and at least one request is high at a rising edge, the grant appears after that edge.
- R6: While a grant is valid and blk_done is low, the grant does not change, whatever happens on the request and level inputs.
- R7: A blk_done pulse while a grant is valid starts a new round using the inputs sampled in that cycle. The new grant appears after that edge. If no channel is requesting, grant_vld goes low.
- R8: The channel whose block has just completed is left out of the next round, both at block-done and at the first request after an idle period. It is considered again in the round after that.
- R9: If the excluded channel is the only channel requesting, it is granted again.
- R10: A blk_done pulse while no grant is valid has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NCH | Request line of each channel |
| level | input | 2*NCH | Priority level of each channel, 2 bits per channel |
| blk_done | input | 1 | One-cycle pulse marking the end of the granted block |
| grant | output | NCH | One-hot grant |
| grant_vld | output | 1 | A grant is active |

## Verification
The bench targets the places where the exclusion rule interacts with fixed priority.

- **Alternation of two very-high channels.** Two very-high channels must alternate, and a low channel must get its turn once they drop. A design that ignores exclusion would keep granting channel 0.
- **Sole excluded requester.** When the just-finished channel is the only requester, it must be granted again. A design that applies exclusion too strictly would leave the bus idle instead.
- **Exclusion across idle.** After an idle gap, the exclusion must still hold. A design that clears the record too early would regrant the same channel.
- **Input changes mid-block.** Changing requests and levels during a block must leave the grant alone. A design that re-arbitrates every cycle would switch grants in the middle of a block.
- **Stray blk_done while idle.** A blk_done pulse with no grant must be ignored. A design that acts on it would raise a spurious grant.

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int NCH = 12,
  parameter int LW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req,
  input  logic [NCH*LW-1:0] level,
  input  logic              blk_done,
  output logic [NCH-1:0]    grant,
  output logic              grant_vld
);

  logic [NCH-1:0] excl_q;
  logic [NCH-1:0] skip, cand, win;
  logic           arb_now;

  assign arb_now = grant_vld ? blk_done : 1'b1;
  assign skip    = grant_vld ? grant : excl_q;

  always_comb begin
    logic [LW-1:0] best_lv;
    logic          found;
    cand = req & ~skip;
    if (cand == '0) cand = req;
    win     = '0;
    best_lv = '0;
    found   = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (cand[i] && (!found || level[i*LW +: LW] > best_lv)) begin
        win     = '0;
        win[i]  = 1'b1;
        best_lv = level[i*LW +: LW];
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant     <= '0;
      grant_vld <= 1'b0;
      excl_q    <= '0;
    end else if (arb_now) begin
      if (grant_vld) excl_q <= grant;
      if (grant_vld || req != '0) begin
        grant     <= win;
        grant_vld <= |req;
      end
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_vld == (grant != '0)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld && !blk_done |=> grant_vld && $stable(grant));

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld && req != '0 |=> grant_vld);

  p_skip_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld && blk_done && (req & ~grant) != '0 |=> (grant & $past(grant)) == '0);

  p_regrant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld && blk_done && req == grant |=> grant == $past(grant));

  p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld && blk_done && req == '0 |=> !grant_vld);

endmodule

// File: tb/dma_prio_arbiter_test.sv
module dma_prio_arbiter_test;
  localparam int NCH = 12;
  localparam int LW  = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    req;
  logic [NCH*LW-1:0] level;
  logic              blk_done;
  logic [NCH-1:0]    grant;
  logic              grant_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_prio_arbiter #(.NCH(NCH), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .level(level),
    .blk_done(blk_done), .grant(grant), .grant_vld(grant_vld)
  );

  // {req, level, expected grant} for a fresh arbiter
  localparam logic [47:0] VEC [6] = '{
    {12'h001, 24'h000000, 12'h001},
    {12'h088, 24'h00C040, 12'h080},
    {12'h224, 24'h080820, 12'h004},
    {12'h800, 24'h000000, 12'h800},
    {12'h412, 24'h300300, 12'h010},
    {12'hFFF, 24'h556555, 12'h040}
  };

  task automatic check(input string tag, input logic [NCH-1:0] exp_g, input logic exp_v);
    checks++;
    if (grant !== exp_g || grant_vld !== exp_v || ($countones(grant) > 1)) begin
      errors++;
      $display("FAIL %s grant=%h vld=%b expected grant=%h vld=%b", tag, grant, grant_vld, exp_g, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; level = '0; blk_done = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_done();
    blk_done = 1'b1;
    @(negedge clk);
    blk_done = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req = '0; level = '0; blk_done = 1'b0;
    do_reset();
    check("R1 reset state", '0, 1'b0);

    for (int k = 0; k < 6; k++) begin
      do_reset();
      req   = VEC[k][47:36];
      level = VEC[k][35:12];
      check("R5 no grant before edge", '0, 1'b0);
      @(negedge clk);
      check($sformatf("R3 R4 R2 vector %0d", k), VEC[k][11:0], 1'b1);
    end

    // R10: done pulse while idle
    do_reset();
    pulse_done();
    check("R10 idle done ignored", '0, 1'b0);

    // interleaving: ch0 and ch1 very high, ch2 low
    level = '0;
    level[1:0] = 2'b11;
    level[3:2] = 2'b11;
    req = 12'h007;
    @(negedge clk);
    check("R4 first grant ch0", 12'h001, 1'b1);
    req = 12'h800;
    level[23:22] = 2'b11;
    @(negedge clk);
    @(negedge clk);
    check("R6 grant held mid-block", 12'h001, 1'b1);
    req = 12'h007;
    level[23:22] = 2'b00;
    pulse_done();
    check("R8 ch0 excluded -> ch1", 12'h002, 1'b1);
    pulse_done();
    check("R8 ch0 back -> ch0", 12'h001, 1'b1);
    req = 12'h004;
    pulse_done();
    check("R7 low channel served", 12'h004, 1'b1);
    pulse_done();
    check("R9 sole excluded regranted", 12'h004, 1'b1);
    req = '0;
    pulse_done();
    check("R7 no request -> idle", '0, 1'b0);
    // exclusion survives idle: ch2 just finished
    req = 12'h024;
    @(negedge clk);
    check("R8 exclusion across idle -> ch5", 12'h020, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule